// File: doc/BRIEF.md
# Multi-Mode Memory Handshake Requester

This block sits on the processor side of an external memory port. An internal command (read or write, with an address and write data) is taken over a valid/ready pair, and the block drives a separate address bus, a separate write-data bus, a request line and a write-enable line toward memory. Read data comes back on its own input bus and is captured into a register, and a one-clock done pulse tells the internal side that the transfer has finished.

How a transfer completes depends only on how two memory-side pins are tied. With the idle pin and the acknowledge pin both held high, every access finishes one clock after it starts (synchronous mode). With the idle pin held low, the block runs a full four-phase handshake: acknowledge is passed through a flop synchronizer, and a new request waits until the synchronized acknowledge has returned low (asynchronous mode). With the idle pin held high and a live acknowledge, the memory is taken to be clocked with the processor, acknowledge is used directly, and a new request may go out on the very next clock without waiting for acknowledge to fall (extended-cycle mode).

Top module: `mem_handshake_req`

## Requirements
- R1: Synchronous mode (idle and acknowledge both high): the request is high for exactly one clock; a command taken at clock edge E raises request after E and pulses done in the cycle after edge E+1.
- R2: While the request is high and the access has not completed, request, write-enable, address and write data hold their values.
- R3: Write-enable is high only while the request is high and only for a write command; it is low for reads and between accesses.
- R4: Asynchronous mode (idle low): acknowledge passes through SYNC_STAGES flops before use; with an acknowledge that rises L clocks after the request, done pulses 1+L+SYNC_STAGES clocks after the accepting clock.
- R5: Asynchronous mode: after an access, no new command is accepted and no request is raised while the synchronized acknowledge is still high, so acknowledge must return low first.
- R6: Extended-cycle mode (idle high, live acknowledge): acknowledge is used without synchronization, done pulses 1+L clocks after the accepting clock, and the next command is accepted on the clock right after done with no return-to-zero wait.
- R7: Read data is captured into the read-data output on the clock edge where the access completes and holds until the next read completes; a write leaves it unchanged.
- R8: Done is a single-clock pulse, given exactly once per accepted command, and only after a cycle with the request high.
- R9: After reset the request, write-enable and done outputs are low, the command-ready output is high and the read-data output is zero.
- R10: Ready is low whenever a request is outstanding; a command is taken only on an edge where valid and ready are both high, and the next cycle presents its address and write flag on the memory side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Internal command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_done | output | 1 | One-clock completion pulse |
| cmd_rdata | output | DATA_W | Captured read data |
| mem_idle | input | 1 | Mode pin: low = four-phase handshake, high = no return-to-zero wait |
| mem_ack | input | 1 | Memory acknowledge (tie high for synchronous mode) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write-enable |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_wdata | output | DATA_W | Memory write-data bus |
| mem_rdata | input | DATA_W | Memory read-data bus |

## Verification
The bench builds the block with a 6-bit address, 12-bit data and a two-stage synchronizer, so a 64-word memory model covers every address, including the top one, and the synchronizer delay shows up as a distinct, predictable two-clock term in the asynchronous completion time. All three modes are run from reset with memory latencies of zero to three clocks and, in the asynchronous case, random delays before acknowledge falls, which exercises the capture window between acknowledge rising and request falling and the return-to-zero wait between accesses.

// File: rtl/mhr_pkg.sv
package mhr_pkg;

   // Two-state access sequencer: waiting for a command, or holding a request.
   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_ACCESS = 1'b1
   } mhr_state_e;

   // A new access may start when the idle pin waives the return-to-zero
   // wait, or when the synchronized acknowledge is already low.
   function automatic logic mhr_start_allowed(input logic idle_pin,
                                              input logic ack_synced);
      return idle_pin | ~ack_synced;
   endfunction

   // Completion source: the raw acknowledge for clock-coupled memory,
   // the synchronized one for the four-phase handshake.
   function automatic logic mhr_pick_ack(input logic idle_pin,
                                         input logic ack_raw,
                                         input logic ack_synced);
      return idle_pin ? ack_raw : ack_synced;
   endfunction

endpackage

// File: rtl/mhr_ack_sync.sv
module mhr_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_in,
   output logic ack_out
);

   generate
      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= ack_in;
         end
         assign ack_out = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], ack_in};
         end
         assign ack_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mhr_ack_select.sv
module mhr_ack_select
   import mhr_pkg::*;
(
   input  logic idle_pin,
   input  logic ack_raw,
   input  logic ack_synced,
   output logic ack_done,
   output logic start_ok
);

   assign ack_done = mhr_pick_ack(idle_pin, ack_raw, ack_synced);
   assign start_ok = mhr_start_allowed(idle_pin, ack_synced);

endmodule

// File: rtl/mhr_ctrl.sv
module mhr_ctrl
   import mhr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic start_ok,
   input  logic ack_done,
   output logic cmd_ready,
   output logic take_cmd,
   output logic finish,
   output logic in_access,
   output logic done_q
);

   mhr_state_e state_q;

   assign in_access = (state_q == ST_ACCESS);
   assign cmd_ready = (state_q == ST_IDLE) && start_ok;
   assign take_cmd  = cmd_valid && cmd_ready;
   assign finish    = in_access && ack_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done_q  <= 1'b0;
      end else begin
         done_q <= finish;
         unique case (state_q)
            ST_IDLE:   if (take_cmd) state_q <= ST_ACCESS;
            ST_ACCESS: if (ack_done) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mhr_hold_regs.sv
module mhr_hold_regs #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take_cmd,
   input  logic          finish,
   input  logic          in_access,
   input  logic          cmd_write,
   input  logic [AW-1:0] cmd_addr,
   input  logic [DW-1:0] cmd_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic [DW-1:0] cmd_rdata
);

   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          write_q;
   logic [DW-1:0] rdata_q;

   // Bus values are loaded only when a command is taken, so they stay put
   // for the whole request however long the memory takes.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
      end else if (take_cmd) begin
         addr_q  <= cmd_addr;
         wdata_q <= cmd_wdata;
         write_q <= cmd_write;
      end
   end

   // Read data is sampled on the completing edge; request is still high
   // then, so the memory is still driving valid data.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   rdata_q <= '0;
      else if (finish && !write_q)  rdata_q <= mem_rdata;
   end

   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign mem_we    = in_access && write_q;
   assign cmd_rdata = rdata_q;

endmodule

// File: rtl/mem_handshake_req.sv
module mem_handshake_req #(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_done,
   output logic [DATA_W-1:0] cmd_rdata,
   input  logic              mem_idle,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int MaxSyncStages = 4;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("mem_handshake_req: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mem_handshake_req: DATA_W must be at least 1");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > MaxSyncStages) begin : g_bad_sync
         $error("mem_handshake_req: SYNC_STAGES out of range");
      end
   endgenerate

   logic ack_synced;
   logic ack_done;
   logic start_ok;
   logic take_cmd;
   logic finish;
   logic in_access;

   mhr_ack_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_in  (mem_ack),
      .ack_out (ack_synced)
   );

   mhr_ack_select i_ack_select (
      .idle_pin   (mem_idle),
      .ack_raw    (mem_ack),
      .ack_synced (ack_synced),
      .ack_done   (ack_done),
      .start_ok   (start_ok)
   );

   mhr_ctrl i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .start_ok  (start_ok),
      .ack_done  (ack_done),
      .cmd_ready (cmd_ready),
      .take_cmd  (take_cmd),
      .finish    (finish),
      .in_access (in_access),
      .done_q    (cmd_done)
   );

   mhr_hold_regs #(.AW(ADDR_W), .DW(DATA_W)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_cmd  (take_cmd),
      .finish    (finish),
      .in_access (in_access),
      .cmd_write (cmd_write),
      .cmd_addr  (cmd_addr),
      .cmd_wdata (cmd_wdata),
      .mem_rdata (mem_rdata),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .cmd_rdata (cmd_rdata)
   );

   assign mem_req = in_access;

endmodule

// File: rtl/mhr_checker.sv
module mhr_checker #(
   parameter int AW = 16,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          cmd_ready,
   input logic          cmd_write,
   input logic [AW-1:0] cmd_addr,
   input logic          cmd_done,
   input logic          mem_idle,
   input logic          mem_ack,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata
);

   assert_sync_one_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_idle && mem_ack && mem_req) |=> (!mem_req && cmd_done));

   assert_bus_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (cmd_done || (mem_req && $stable(mem_addr) &&
                                $stable(mem_wdata) && $stable(mem_we))));

   assert_we_inside_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

   assert_rtz_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_idle && mem_ack && !mem_req) |=> !mem_req);

   assert_ext_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_idle && !mem_req) |-> cmd_ready);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done);

   assert_done_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |-> $past(mem_req));

   assert_ready_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !mem_req);

   assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=>
         (mem_req && mem_addr == $past(cmd_addr) && mem_we == $past(cmd_write)));

endmodule

bind mem_handshake_req mhr_checker #(.AW(ADDR_W), .DW(DATA_W)) i_mhr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_write (cmd_write),
   .cmd_addr  (cmd_addr),
   .cmd_done  (cmd_done),
   .mem_idle  (mem_idle),
   .mem_ack   (mem_ack),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata)
);

// File: tb/test_mem_handshake_req.sv
module test_mem_handshake_req;

   localparam int AW    = 6;
   localparam int DW    = 12;
   localparam int SS    = 2;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic          cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic          cmd_done;
   logic [DW-1:0] cmd_rdata;
   logic          mem_idle = 1'b1;
   logic          mem_ack = 1'b1;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;

   always #10 clk = ~clk;

   mem_handshake_req #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) i_mem_handshake_req (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .mem_idle(mem_idle),
      .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   int mode = 0;          // 0 synchronous, 1 extended cycle, 2 four-phase
   int mem_lat = 0;
   int drop_hold = 0;
   int hold_left = 0;
   int cnt = 0;
   bit had_access = 0;
   logic [DW-1:0] model_mem [DEPTH];
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] last_read = '0;

   function automatic logic [DW-1:0] init_word(input int i);
      return DW'(i * 29 + 5);
   endfunction

   function automatic int exp_latency(input int m, input int lat);
      if (m == 0) return 1;
      if (m == 1) return 1 + lat;
      return 1 + lat + SS;
   endfunction

   function automatic string mode_tag(input int m);
      if (m == 0) return "R1";
      if (m == 1) return "R6";
      return "R4";
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Memory model, updated away from the rising edge.
   always @(negedge clk) begin
      if (mode == 0) begin
         mem_ack = 1'b1;
         if (mem_req) begin
            mem_rdata = model_mem[mem_addr];
            if (mem_we) model_mem[mem_addr] = mem_wdata;
         end else begin
            mem_rdata = DW'($urandom);
         end
      end else if (mem_req) begin
         if (!mem_ack) begin
            if (cnt >= mem_lat) begin
               mem_ack   = 1'b1;
               hold_left = drop_hold;
               mem_rdata = model_mem[mem_addr];
               if (mem_we) model_mem[mem_addr] = mem_wdata;
            end else begin
               cnt++;
            end
         end
      end else begin
         cnt = 0;
         if (mem_ack && hold_left > 0) hold_left--;
         else mem_ack = 1'b0;
         mem_rdata = DW'($urandom);
      end
   end

   task automatic do_reset();
      rst_n = 1'b0;
      cmd_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      last_read = '0;
      had_access = 0;
      chk(mem_req == 1'b0,   "R9 req",   mem_req, 0);
      chk(mem_we == 1'b0,    "R9 we",    mem_we, 0);
      chk(cmd_done == 1'b0,  "R9 done",  cmd_done, 0);
      chk(cmd_ready == 1'b1, "R9 ready", cmd_ready, 1);
      chk(cmd_rdata == '0,   "R9 rdata", cmd_rdata, 0);
   endtask

   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int lat);
      int waited = 0;
      int n = 0;
      mem_lat   = lat;
      cmd_valid = 1'b1;
      cmd_write = wr;
      cmd_addr  = a;
      cmd_wdata = d;
      while (!cmd_ready && waited < 1000) begin
         @(negedge clk);
         waited++;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(mem_req == 1'b1, "R10 request after accept", mem_req, 1);
      chk(mem_we == wr,    "R3 write-enable follows command", mem_we, wr);
      if (mode == 2 && had_access)
         chk(waited >= 1, "R5 return-to-zero wait", waited, 1);
      else
         chk(waited == 0, "R6 no wait before accept", waited, 0);
      while (!cmd_done && n < 1000) begin
         @(negedge clk);
         n++;
      end
      chk(n == exp_latency(mode, lat), mode_tag(mode), n, exp_latency(mode, lat));
      if (wr) begin
         chk(cmd_rdata == last_read, "R7 write keeps read data", cmd_rdata, last_read);
         ref_mem[a] = d;
      end else begin
         chk(cmd_rdata == ref_mem[a], "R7 read data", cmd_rdata, ref_mem[a]);
         last_read = ref_mem[a];
      end
      @(negedge clk);
      chk(cmd_done == 1'b0, "R8 done single pulse", cmd_done, 0);
      had_access = 1;
   endtask

   task automatic random_run(input int count, input int max_lat, input int max_hold);
      for (int k = 0; k < count; k++) begin
         drop_hold = (max_hold > 0) ? int'($urandom % (max_hold + 1)) : 0;
         access(1'($urandom), AW'($urandom), DW'($urandom),
                (max_lat > 0) ? int'($urandom % (max_lat + 1)) : 0);
      end
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < DEPTH; i++) begin
         model_mem[i] = init_word(i);
         ref_mem[i]   = init_word(i);
      end

      // Synchronous mode: both pins high.
      mode = 0; mem_idle = 1'b1; drop_hold = 0;
      do_reset();
      access(1'b0, '0, '0, 0);
      access(1'b1, AW'(DEPTH - 1), '1, 0);
      access(1'b0, AW'(DEPTH - 1), '0, 0);
      access(1'b1, AW'(DEPTH - 1), '0, 0);
      access(1'b0, AW'(DEPTH - 1), '0, 0);
      random_run(30, 0, 0);

      // Extended-cycle mode: idle high, live acknowledge.
      mode = 1; mem_idle = 1'b1; drop_hold = 0;
      do_reset();
      access(1'b1, 6'd5, 12'hA5A, 0);
      access(1'b0, 6'd5, '0, 3);
      access(1'b0, 6'd5, '0, 0);
      random_run(30, 3, 0);

      // Four-phase mode: idle low.
      mode = 2; mem_idle = 1'b0; drop_hold = 0;
      do_reset();
      access(1'b1, 6'd9, 12'h3C3, 0);
      access(1'b0, 6'd9, '0, 0);
      drop_hold = 2;
      access(1'b1, 6'd9, 12'h0F0, 2);
      access(1'b0, 6'd9, '0, 1);
      random_run(30, 3, 2);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule